// File: doc/BRIEF.md
# Cascaded Programmable Clock Divider

This block divides a fast input clock in two steps. A coarse prescaler divides by one of a small, sparse set of ratios (4, 5, 6, 7, 9 or 11) chosen by a 3-bit code. A fine divider then divides the prescaler output by 1 or by any even value from 2 to 128, chosen by a 7-bit code that holds the ratio minus one. Both stages run on the input clock as enable-driven counters. The divided clock comes out of a register, so it cannot glitch. Its period is the product of the two ratios.

A new configuration is captured on a single-cycle load strobe and held as pending. It is applied only at the boundary of an output period, so the old period always completes and the first edge under the new ratios is a rising edge. A prescaler code outside the legal set does not stop the load. The prescaler keeps the last legal ratio, the fine ratio is still taken, and a flag reports the bad code. When the fine ratio is even, the output has an exact 50% duty cycle whatever the prescaler ratio. At divide-by-1 the output follows the prescaler shape, which is high for the larger half of an odd ratio.

Top module: `cascadeClkDiv`

## Requirements
- R1: During reset `clkOut` and `illegalCfg` are low and the ratios come from the reset codes (default 4 x 1). The first clock edge after reset is released starts an output period, so `clkOut` goes high.
- R2: Prescaler codes decode as 000=4, 001=5, 010=6, 011=7, 101=9 and 111=11.
- R3: The fine ratio is the 7-bit code plus one. An odd result above 1 is raised to the next even value (code 2 gives 4). Code 0 gives divide-by-1, and code 127 gives 128.
- R4: The `clkOut` period is prescaler ratio times fine ratio, in input cycles. With an even fine ratio, `clkOut` is high for exactly half the period, starting at the period's first cycle.
- R5: With fine ratio 1, `clkOut` is high for ceil(H/2) cycles and low for floor(H/2) cycles, where H is the prescaler ratio.
- R6: A load is captured at the clock edge where `load` is high. The captured configuration takes effect at the first output period that begins after that edge. Of several loads in one period, the last one wins.
- R7: Codes 100 and 110 are illegal. A load with an illegal prescaler code keeps the last legal prescaler ratio but still applies the fine ratio. `illegalCfg` is high from the cycle after such a load until the cycle after the next load with a legal code.
- R8: Every high phase and every low phase of `clkOut` lasts at least 2 input cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rstN | input | 1 | Active-low synchronous reset |
| hsCode | input | 3 | Encoded prescaler ratio |
| nCode | input | 7 | Fine divider ratio minus one |
| load | input | 1 | Capture strobe for both codes |
| clkOut | output | 1 | Divided clock |
| illegalCfg | output | 1 | Last load carried an illegal prescaler code |

## Verification
A wrong prescaler or fine counter bound shows up as a wrong `clkOut` period within one output period of the next apply boundary. A wrong duty cycle shows up at the very next falling edge. If the pending configuration is lost or applied at the wrong time, the output period changes at the wrong rising edge, so the per-cycle comparison fails within one period of the load. A flag that is set or cleared wrongly is visible one cycle after the offending load.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int HS_CODE_W  = 3;
  localparam int HS_RATIO_W = 4;
  localparam int N_CODE_W   = 7;
  localparam int N_RATIO_W  = N_CODE_W + 1;

  typedef struct packed {
    logic                  apply;
    logic [HS_RATIO_W-1:0] hsRatio;
    logic [N_RATIO_W-1:0]  nRatio;
  } divCmd_t;

  // Returns {legal, ratio}; illegal codes report ratio 4 and legal=0
  function automatic logic [HS_RATIO_W:0] hsDecode(input logic [HS_CODE_W-1:0] code);
    case (code)
      3'b000:  return {1'b1, 4'd4};
      3'b001:  return {1'b1, 4'd5};
      3'b010:  return {1'b1, 4'd6};
      3'b011:  return {1'b1, 4'd7};
      3'b101:  return {1'b1, 4'd9};
      3'b111:  return {1'b1, 4'd11};
      default: return {1'b0, 4'd4};
    endcase
  endfunction

  function automatic logic [N_RATIO_W-1:0] nDecode(input logic [N_CODE_W-1:0] code);
    logic [N_RATIO_W-1:0] r;
    r = {1'b0, code} + N_RATIO_W'(1);
    if (r[0] && (r != N_RATIO_W'(1))) r = r + N_RATIO_W'(1);
    return r;
  endfunction
endpackage

// File: rtl/cdivCtrl.sv
module cdivCtrl
  import cdiv_pkg::*;
#(
  parameter logic [HS_CODE_W-1:0] RESET_HS_CODE = '0,
  parameter logic [N_CODE_W-1:0]  RESET_N_CODE  = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [HS_CODE_W-1:0] hsCode,
  input  logic [N_CODE_W-1:0]  nCode,
  input  logic                 load,
  input  logic                 frameEnd,
  output divCmd_t              cmd,
  output logic                 illegalCfg
);
  localparam logic [HS_RATIO_W:0]  RST_HS_DEC = hsDecode(RESET_HS_CODE);
  localparam logic [N_RATIO_W-1:0] RST_N      = nDecode(RESET_N_CODE);

  logic [HS_RATIO_W-1:0] pendHs;
  logic [N_RATIO_W-1:0]  pendN;
  logic                  pendValid;
  logic [HS_RATIO_W:0]   hsDec;

  assign hsDec = hsDecode(hsCode);

  // Apply uses the pending set as it stood before this edge's load
  assign cmd.apply   = frameEnd && pendValid;
  assign cmd.hsRatio = pendHs;
  assign cmd.nRatio  = pendN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendHs     <= RST_HS_DEC[HS_RATIO_W-1:0];
      pendN      <= RST_N;
      pendValid  <= 1'b0;
      illegalCfg <= 1'b0;
    end else begin
      if (cmd.apply) pendValid <= 1'b0;
      if (load) begin
        pendValid <= 1'b1;
        pendN     <= nDecode(nCode);
        if (hsDec[HS_RATIO_W]) begin
          pendHs     <= hsDec[HS_RATIO_W-1:0];
          illegalCfg <= 1'b0;
        end else begin
          illegalCfg <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cdivCore.sv
module cdivCore
  import cdiv_pkg::*;
#(
  parameter logic [HS_CODE_W-1:0] RESET_HS_CODE = '0,
  parameter logic [N_CODE_W-1:0]  RESET_N_CODE  = '0
) (
  input  logic    clk,
  input  logic    rstN,
  input  divCmd_t cmd,
  output logic    frameEnd,
  output logic    clkOut
);
  localparam logic [HS_RATIO_W:0]    RST_HS_DEC = hsDecode(RESET_HS_CODE);
  localparam logic [HS_RATIO_W-1:0]  RST_HS     = RST_HS_DEC[HS_RATIO_W-1:0];
  localparam logic [N_RATIO_W-1:0]   RST_N      = nDecode(RESET_N_CODE);

  logic [HS_RATIO_W-1:0] hsR, hsNext;
  logic [N_RATIO_W-1:0]  nR, nNext;
  logic [HS_RATIO_W-1:0] preCnt, preNext;
  logic [N_RATIO_W-1:0]  postCnt, postNext;
  logic                  preWrap;
  logic                  levelNext;
  logic [HS_RATIO_W:0]   preHighLen;

  // Prescaler stage wraps every hsR cycles; fine stage counts those wraps
  assign preWrap  = (preCnt == hsR - HS_RATIO_W'(1));
  assign frameEnd = preWrap && (postCnt == nR - N_RATIO_W'(1));

  always_comb begin
    hsNext   = hsR;
    nNext    = nR;
    preNext  = preCnt + HS_RATIO_W'(1);
    postNext = postCnt;
    if (frameEnd) begin
      preNext  = '0;
      postNext = '0;
      if (cmd.apply) begin
        hsNext = cmd.hsRatio;
        nNext  = cmd.nRatio;
      end
    end else if (preWrap) begin
      preNext  = '0;
      postNext = postCnt + N_RATIO_W'(1);
    end
    preHighLen = ({1'b0, hsNext} + (HS_RATIO_W+1)'(1)) >> 1;
    if (nNext == N_RATIO_W'(1))
      levelNext = ({1'b0, preNext} < preHighLen);
    else
      levelNext = (postNext < (nNext >> 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsR     <= RST_HS;
      nR      <= RST_N;
      preCnt  <= RST_HS - HS_RATIO_W'(1);
      postCnt <= RST_N - N_RATIO_W'(1);
      clkOut  <= 1'b0;
    end else begin
      hsR     <= hsNext;
      nR      <= nNext;
      preCnt  <= preNext;
      postCnt <= postNext;
      clkOut  <= levelNext;
    end
  end
endmodule

// File: rtl/cascadeClkDiv.sv
module cascadeClkDiv
  import cdiv_pkg::*;
#(
  parameter logic [HS_CODE_W-1:0] RESET_HS_CODE = '0,
  parameter logic [N_CODE_W-1:0]  RESET_N_CODE  = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [HS_CODE_W-1:0] hsCode,
  input  logic [N_CODE_W-1:0]  nCode,
  input  logic                 load,
  output logic                 clkOut,
  output logic                 illegalCfg
);
  divCmd_t cmd;
  logic    frameEnd;

  cdivCtrl #(.RESET_HS_CODE(RESET_HS_CODE), .RESET_N_CODE(RESET_N_CODE)) ctrl_i (
    .clk(clk), .rstN(rstN), .hsCode(hsCode), .nCode(nCode), .load(load),
    .frameEnd(frameEnd), .cmd(cmd), .illegalCfg(illegalCfg)
  );

  cdivCore #(.RESET_HS_CODE(RESET_HS_CODE), .RESET_N_CODE(RESET_N_CODE)) core_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .frameEnd(frameEnd), .clkOut(clkOut)
  );
endmodule

// File: rtl/cascadeClkDiv_chk.sv
module cascadeClkDiv_chk (
  input logic clk,
  input logic rstN,
  input logic load,
  input logic clkOut,
  input logic illegalCfg
);
  // R8
  min_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkOut) |=> clkOut);
  // R8
  min_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkOut) |=> !clkOut);
  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(illegalCfg) |-> $past(load));
  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(illegalCfg) |-> $past(load));
  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(load) |-> $stable(illegalCfg));
endmodule

bind cascadeClkDiv cascadeClkDiv_chk chk_i (
  .clk(clk), .rstN(rstN), .load(load), .clkOut(clkOut), .illegalCfg(illegalCfg)
);

// File: tb/cascadeClkDiv_tb_top.sv
module cascadeClkDiv_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] hsCode = '0;
  logic [6:0] nCode = '0;
  logic       load = 1'b0;
  logic       clkOut, illegalCfg;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  cascadeClkDiv dut_i (
    .clk(clk), .rstN(rstN), .hsCode(hsCode), .nCode(nCode), .load(load),
    .clkOut(clkOut), .illegalCfg(illegalCfg)
  );

  // Ratio tables from R2 and R3; 0 marks an illegal prescaler code
  function automatic int expHs(input logic [2:0] c);
    case (c)
      3'd0: return 4;  3'd1: return 5;  3'd2: return 6;
      3'd3: return 7;  3'd5: return 9;  3'd7: return 11;
      default: return 0;
    endcase
  endfunction

  function automatic int expN(input logic [6:0] c);
    int r = int'(c) + 1;
    if (r > 1 && (r % 2) == 1) r = r + 1;
    return r;
  endfunction

  function automatic bit expLevel(input int ph, input int h, input int n);
    if (n == 1) return ph < (h + 1) / 2;
    return ph < (h * n) / 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Period-phase reference model (R4 R5 R6 R7)
  int mPh, mH, mN, mPendH, mPendN;
  bit mPendV, mIll, mOut;
  always @(posedge clk) begin
    if (!rstN) begin
      mH = 4; mN = 1; mPh = mH * mN - 1; mOut = 0;
      mPendH = 4; mPendN = 1; mPendV = 0; mIll = 0;
    end else begin
      if (mPh == mH * mN - 1) begin
        mPh = 0;
        if (mPendV) begin mH = mPendH; mN = mPendN; mPendV = 0; end
      end else mPh++;
      if (load) begin
        mPendV = 1;
        mPendN = expN(nCode);
        if (expHs(hsCode) != 0) begin mPendH = expHs(hsCode); mIll = 0; end
        else mIll = 1;
      end
      mOut = expLevel(mPh, mH, mN);
    end
  end

  bit modelOn = 0;
  always @(negedge clk) begin
    if (modelOn && rstN) begin
      check(clkOut == mOut, "R4_R6 cycle clkOut", clkOut, mOut);
      check(illegalCfg == mIll, "R7 cycle illegalCfg", illegalCfg, mIll);
    end
  end

  task automatic doLoad(input logic [2:0] h, input logic [6:0] n);
    hsCode = h; nCode = n; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  // Wait at negedges for a clkOut rise; returns 0 on timeout
  task automatic waitRise(output bit ok);
    bit prev = clkOut;
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!prev && clkOut) begin ok = 1; return; end
      prev = clkOut;
    end
  endtask

  task automatic measure(input logic [2:0] h, input logic [6:0] n,
                         input int eh, input int en, input string req);
    bit ok;
    int hi = 0, per = 0, expHi;
    doLoad(h, n);
    waitRise(ok);
    if (ok) waitRise(ok);
    if (!ok) begin check(0, req, 0, 1); return; end
    hi = 1; per = 1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (clkOut && hi == per) hi++;
      if (!clkOut || hi != per + 1) begin
        if (clkOut && hi != per + 1 && per > hi) break;
      end
      per++;
      if (clkOut && per > hi) begin per--; break; end
    end
    expHi = (en == 1) ? (eh + 1) / 2 : (eh * en) / 2;
    check(per == eh * en, {req, " period"}, per, eh * en);
    check(hi == expHi, {req, " high time"}, hi, expHi);
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", wd);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h00c0ffee));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(clkOut == 1'b0, "R1 clkOut in reset", clkOut, 0);
    check(illegalCfg == 1'b0, "R1 illegalCfg in reset", illegalCfg, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(clkOut == 1'b1, "R1 first edge after reset", clkOut, 1);
    modelOn = 1;
    // R1: default ratio 4 x 1
    measure(3'd0, 7'd0, 4, 1, "R1 default 4x1");
    // R2 / R5: every legal prescaler code at divide-by-1
    measure(3'd1, 7'd0, 5, 1, "R2_R5 code001");
    measure(3'd2, 7'd0, 6, 1, "R2_R5 code010");
    measure(3'd3, 7'd0, 7, 1, "R2_R5 code011");
    measure(3'd5, 7'd0, 9, 1, "R2_R5 code101");
    measure(3'd7, 7'd0, 11, 1, "R2_R5 code111");
    // R3 / R4: even, rounded-up odd, and maximum fine ratios
    measure(3'd1, 7'd1, 5, 2, "R3_R4 n code1");
    measure(3'd1, 7'd2, 5, 4, "R3_R4 n code2 rounds");
    measure(3'd3, 7'd8, 7, 10, "R3_R4 n code8 rounds");
    measure(3'd7, 7'd127, 11, 128, "R3_R4 n code127");
    // R7: illegal code keeps last legal prescaler, fine still applies
    measure(3'd2, 7'd1, 6, 2, "R7 legal before");
    measure(3'd4, 7'd3, 6, 4, "R7 illegal100");
    check(illegalCfg == 1'b1, "R7 flag after 100", illegalCfg, 1);
    measure(3'd6, 7'd5, 6, 6, "R7 illegal110");
    check(illegalCfg == 1'b1, "R7 flag after 110", illegalCfg, 1);
    measure(3'd0, 7'd1, 4, 2, "R7 legal clears");
    check(illegalCfg == 1'b0, "R7 flag cleared", illegalCfg, 0);
    // R6: two loads in one period, the last one wins
    doLoad(3'd3, 7'd5);
    measure(3'd1, 7'd3, 5, 4, "R6 last load wins");
    // R6 R8: random loads checked cycle by cycle against the model
    for (int k = 0; k < 150; k++) begin
      int gap = $urandom_range(1, 300);
      doLoad(3'($urandom_range(0, 7)), 7'($urandom_range(0, 20)));
      repeat (gap) @(negedge clk);
    end
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule